// File: doc/BRIEF.md
# Register-Mapped SPI Flash Command Engine

This block is a single-lane SPI master that a host drives through a small byte-addressed register window. It is used to send arbitrary commands to a serial flash device. The host performs these steps:

1. Place the opcode in a dedicated register.
2. Set a transmit byte count and a receive byte count.
3. Load the outgoing payload into a 71-byte shared data buffer.
4. Write the execute bit.

The engine sends the opcode first, MSB first, in SPI mode 0. It then sends the transmit payload. After that it clocks in the requested number of response bytes and writes each one back into the same buffer, directly after the transmit payload. The buffer index wraps around its 71 entries. A busy flag stays high for the whole frame and drops when chip select releases.

Host accesses are byte, halfword or word wide. Lanes are little-endian: byte k of the access data maps to address `addr+k`. Four 4-bit speed fields are stored and read back. The top field selects the SCK half-period.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every register and buffer byte reads 0, chip select is high (inactive), SCK is low and the busy flag (bit 31 of the word at 0x00) is 0.
- R2: The following fields read back exactly what was written, through byte, halfword and word accesses:
  - the opcode byte at 0x00;
  - the 3-bit read mode, with bits [2:1] at word bits 30:29 and bit [0] at word bit 18 of 0x00;
  - the enable bit at bit 0 of 0x20;
  - the 16-bit speed word at 0x22;
  - the transmit count byte at 0x48;
  - the receive count byte at 0x4B.
- R3: Writing 1 to bit 16 of the word at 0x00 starts a frame when enable is 1 and both counts are within the limit. While the frame runs, bits 31 and 16 both read 1. Both read 0 once chip select has released.
- R4: A frame shifts out, MSB first, the opcode, then buffer entries 0 to txCount-1, then one all-zero byte per receive byte.
- R5: Receive byte n is stored at buffer index (txCount + n) mod 71. The buffer occupies addresses 0x80 to 0xC6. Entries outside the receive window keep their contents.
- R6: If an execute request arrives while either count is above 68, the request is rejected: no frame starts and bit 20 of the word at 0x00 is set. The next accepted start clears bit 20.
- R7: An execute request made while the enable bit is 0 has no effect. No frame starts and chip select stays high.
- R8: Chip select goes low two SCK half-periods before the first rising SCK edge. SCK high and low phases each last one half-period. Chip select returns high together with the final falling SCK edge, one half-period after the last rising edge.
- R9: The speed field at bits 15:12 of 0x22 sets the SCK half-period in clock cycles as follows:

  | Code | Half-period (cycles) |
  |------|----------------------|
  | 4 | 1 |
  | 0 | 2 |
  | 1 | 3 |
  | 2 | 5 |
  | 3 | 6 |
  | 7, reserved 5 and 6, and every other value | 125 |

- R10: While a frame is running, host writes to any register or buffer byte are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host access valid this cycle |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostSize | input | 2 | 0 = byte, 1 = halfword, 2 or 3 = word |
| hostAddr | input | 8 | Byte address of the access |
| hostWdata | input | 32 | Write data; byte k goes to address hostAddr+k |
| hostRdata | output | 32 | Read data, combinational, lane k from address hostAddr+k |
| spiSck | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The assertions check the following every cycle:
- the SPI lines are idle whenever the engine is idle;
- a start and chip select falling coincide, and the end of busy coincides with chip select and SCK releasing;
- SCK never rises without chip select;
- no frame starts with an over-limit count;
- the counts never move during a frame.

Only the bench scenarios can show the rest. This covers the bit order on MOSI, the receive data landing at the wrapped buffer indices, the lead, phase and tail durations for each speed code, the rejection flag, and the lockout of host writes.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH
  } engState_t;

  // Strobes and position that the control hands to the datapath
  typedef struct packed {
    logic       start;
    logic       sample;
    logic       shift;
    logic [2:0] bitPos;
    logic [7:0] byteIdx;
  } engStrobe_t;

  // SCK half-period in clock cycles, before scaling
  function automatic logic [7:0] baseHalf(input logic [3:0] code);
    case (code)
      4'd4:    return 8'd1;
      4'd0:    return 8'd2;
      4'd1:    return 8'd3;
      4'd2:    return 8'd5;
      4'd3:    return 8'd6;
      default: return 8'd125;
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH   = 71,
  parameter int MAX_PAYLOAD = BUF_DEPTH - 3,
  parameter int SCK_SCALE   = 1,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostSel,
  input  logic             hostWr,
  input  logic [1:0]       hostSize,
  input  logic [7:0]       hostAddr,
  input  logic [31:0]      hostWdata,
  output logic [31:0]      hostRdata,
  input  engStrobe_t       strobe,
  input  logic             busy,
  input  logic             miso,
  output logic             mosi,
  output logic             execReq,
  output logic [CNT_W-1:0] halfCnt,
  output logic [7:0]       txCount,
  output logic [7:0]       rxCount
);

  localparam int          IDX_W    = $clog2(BUF_DEPTH);
  localparam logic [8:0]  A_CMD    = 9'h000;
  localparam logic [8:0]  A_CTL2   = 9'h002;
  localparam logic [8:0]  A_CTL3   = 9'h003;
  localparam logic [8:0]  A_ENA    = 9'h020;
  localparam logic [8:0]  A_SPD_LO = 9'h022;
  localparam logic [8:0]  A_SPD_HI = 9'h023;
  localparam logic [8:0]  A_TXCNT  = 9'h048;
  localparam logic [8:0]  A_RXCNT  = 9'h04B;
  localparam logic [8:0]  BUF_LO   = 9'h080;
  localparam logic [8:0]  BUF_HI   = BUF_LO + 9'(BUF_DEPTH);

  logic [7:0]  opcode;
  logic [2:0]  rdMode;
  logic        enable;
  logic [15:0] speed;
  logic        cntErr;
  logic [7:0]  dataBuf [BUF_DEPTH];
  logic [7:0]  txShift;
  logic [7:0]  rxShift;

  logic [2:0]  nBytes;
  logic        hostWrEn;
  logic [8:0]  laneAddr [4];
  logic [7:0]  laneData [4];
  logic [3:0]  laneWr;
  logic        execWrite;
  logic        countOk;

  function automatic logic [IDX_W-1:0] wrapIdx(input logic [7:0] v);
    logic [7:0] r;
    r = (v >= 8'(BUF_DEPTH)) ? v - 8'(BUF_DEPTH) : v;
    return IDX_W'(r);
  endfunction

  function automatic logic inBuf(input logic [8:0] a);
    return (a >= BUF_LO) && (a < BUF_HI);
  endfunction

  assign nBytes   = (hostSize == 2'd0) ? 3'd1 : (hostSize == 2'd1) ? 3'd2 : 3'd4;
  assign hostWrEn = hostSel && hostWr && !busy;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign laneAddr[k] = {1'b0, hostAddr} + 9'(k);
    assign laneData[k] = hostWdata[8*k +: 8];
    assign laneWr[k]   = hostWrEn && (3'(k) < nBytes);
  end

  always_comb begin
    execWrite = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (laneWr[k] && laneAddr[k] == A_CTL2 && laneData[k][0]) execWrite = 1'b1;
    end
  end

  assign countOk = (txCount <= 8'(MAX_PAYLOAD)) && (rxCount <= 8'(MAX_PAYLOAD));
  assign execReq = execWrite && enable && countOk;
  assign halfCnt = CNT_W'(32'(baseHalf(speed[15:12])) * SCK_SCALE);
  assign mosi    = txShift[7];

  // Control and configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcode  <= '0;
      rdMode  <= '0;
      enable  <= 1'b0;
      speed   <= '0;
      txCount <= '0;
      rxCount <= '0;
      cntErr  <= 1'b0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (laneWr[k]) begin
          case (laneAddr[k])
            A_CMD:    opcode       <= laneData[k];
            A_CTL2:   rdMode[0]    <= laneData[k][2];
            A_CTL3:   rdMode[2:1]  <= laneData[k][6:5];
            A_ENA:    enable       <= laneData[k][0];
            A_SPD_LO: speed[7:0]   <= laneData[k];
            A_SPD_HI: speed[15:8]  <= laneData[k];
            A_TXCNT:  txCount      <= laneData[k];
            A_RXCNT:  rxCount      <= laneData[k];
            default:  ;
          endcase
        end
      end
      if (execReq)                            cntErr <= 1'b0;
      else if (execWrite && enable && !countOk) cntErr <= 1'b1;
    end
  end

  // Shared buffer: host writes when idle, engine stores received bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_DEPTH; i++) dataBuf[i] <= '0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (laneWr[k] && inBuf(laneAddr[k]))
          dataBuf[IDX_W'(laneAddr[k] - BUF_LO)] <= laneData[k];
      end
      if (strobe.sample && strobe.bitPos == 3'd7 && strobe.byteIdx > txCount)
        dataBuf[wrapIdx(strobe.byteIdx - 8'd1)] <= {rxShift[6:0], miso};
    end
  end

  // Shift registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.start) begin
        txShift <= opcode;
      end else if (strobe.shift) begin
        if (strobe.bitPos == 3'd7)
          txShift <= (strobe.byteIdx < txCount) ? dataBuf[wrapIdx(strobe.byteIdx)] : 8'h00;
        else
          txShift <= {txShift[6:0], 1'b0};
      end
      if (strobe.sample) rxShift <= {rxShift[6:0], miso};
    end
  end

  // Host read mux
  always_comb begin
    hostRdata = '0;
    for (int k = 0; k < 4; k++) begin
      if (hostSel && 3'(k) < nBytes) begin
        case (laneAddr[k])
          A_CMD:    hostRdata[8*k +: 8] = opcode;
          A_CTL2:   hostRdata[8*k +: 8] = {3'b000, cntErr, 1'b0, rdMode[0], 1'b0, busy};
          A_CTL3:   hostRdata[8*k +: 8] = {busy, rdMode[2:1], 5'b00000};
          A_ENA:    hostRdata[8*k +: 8] = {7'd0, enable};
          A_SPD_LO: hostRdata[8*k +: 8] = speed[7:0];
          A_SPD_HI: hostRdata[8*k +: 8] = speed[15:8];
          A_TXCNT:  hostRdata[8*k +: 8] = txCount;
          A_RXCNT:  hostRdata[8*k +: 8] = rxCount;
          default:
            if (inBuf(laneAddr[k])) hostRdata[8*k +: 8] = dataBuf[IDX_W'(laneAddr[k] - BUF_LO)];
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             execReq,
  input  logic [CNT_W-1:0] halfCnt,
  input  logic [7:0]       txCount,
  input  logic [7:0]       rxCount,
  output engStrobe_t       strobe,
  output logic             sck,
  output logic             csN,
  output logic             busy
);

  engState_t        state;
  logic [CNT_W:0]   divCnt;
  logic [2:0]       bitPos;
  logic [7:0]       byteIdx;
  logic [7:0]       lastIdx;
  logic             tick;
  logic             lastBit;
  logic [CNT_W:0]   halfLoad;
  logic [CNT_W:0]   leadLoad;

  assign lastIdx  = txCount + rxCount;
  assign tick     = (divCnt == '0);
  assign lastBit  = (bitPos == 3'd7) && (byteIdx == lastIdx);
  assign halfLoad = {1'b0, halfCnt} - 1'b1;
  assign leadLoad = {halfCnt, 1'b0} - 1'b1;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe.start   = (state == ST_IDLE) && execReq;
    strobe.sample  = (state == ST_LOW) && tick;
    strobe.shift   = (state == ST_HIGH) && tick && !lastBit;
    strobe.bitPos  = bitPos;
    strobe.byteIdx = byteIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitPos  <= '0;
      byteIdx <= '0;
      sck     <= 1'b0;
      csN     <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (execReq) begin
            state   <= ST_LOW;
            divCnt  <= leadLoad;
            bitPos  <= '0;
            byteIdx <= '0;
            csN     <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sck    <= 1'b1;
            state  <= ST_HIGH;
            divCnt <= halfLoad;
          end else begin
            divCnt <= divCnt - 1'b1;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sck <= 1'b0;
            if (lastBit) begin
              state <= ST_IDLE;
              csN   <= 1'b1;
            end else begin
              state  <= ST_LOW;
              divCnt <= halfLoad;
              bitPos <= bitPos + 3'd1;
              if (bitPos == 3'd7) byteIdx <= byteIdx + 8'd1;
            end
          end else begin
            divCnt <= divCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH   = 71,
  parameter int MAX_PAYLOAD = BUF_DEPTH - 3,
  parameter int SCK_SCALE   = 1,
  parameter int CNT_W       = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWr,
  input  logic [1:0]  hostSize,
  input  logic [7:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        spiSck,
  output logic        spiCsN,
  output logic        spiMosi,
  input  logic        spiMiso
);

  engStrobe_t       strobe;
  logic             engBusy;
  logic             execReq;
  logic [CNT_W-1:0] halfCnt;
  logic [7:0]       txCount;
  logic [7:0]       rxCount;

  spi_cmd_regs #(
    .BUF_DEPTH  (BUF_DEPTH),
    .MAX_PAYLOAD(MAX_PAYLOAD),
    .SCK_SCALE  (SCK_SCALE),
    .CNT_W      (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostSize (hostSize),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .hostRdata(hostRdata),
    .strobe   (strobe),
    .busy     (engBusy),
    .miso     (spiMiso),
    .mosi     (spiMosi),
    .execReq  (execReq),
    .halfCnt  (halfCnt),
    .txCount  (txCount),
    .rxCount  (rxCount)
  );

  spi_cmd_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .execReq(execReq),
    .halfCnt(halfCnt),
    .txCount(txCount),
    .rxCount(rxCount),
    .strobe (strobe),
    .sck    (spiSck),
    .csN    (spiCsN),
    .busy   (engBusy)
  );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int MAX_PAYLOAD = 68
) (
  input logic       clk,
  input logic       rstN,
  input logic       sck,
  input logic       csN,
  input logic       busy,
  input logic [7:0] txCount,
  input logic [7:0] rxCount
);

  // R8: lines idle whenever no frame runs
  p_idle_lines_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN && !sck));

  // R3: a start pulls chip select low in the same cycle
  p_start_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $fell(csN));

  // R8: end of frame releases chip select with the last SCK fall
  p_end_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($rose(csN) && $fell(sck)));

  // R8: SCK never rises without chip select
  p_sck_needs_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> !csN);

  // R6: no frame starts with an over-limit count
  p_count_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ((txCount <= 8'(MAX_PAYLOAD)) && (rxCount <= 8'(MAX_PAYLOAD))));

  // R10: counts frozen during a frame
  p_counts_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(txCount) && $stable(rxCount)));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
  .MAX_PAYLOAD(MAX_PAYLOAD)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sck    (spiSck),
  .csN    (spiCsN),
  .busy   (engBusy),
  .txCount(txCount),
  .rxCount(rxCount)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;

  localparam int DEPTH = 71;
  localparam int NVEC  = 7;
  // {opcode, txCount, rxCount, speed code}
  localparam logic [31:0] VEC [NVEC] = '{
    32'h9F_00_03_04,
    32'h03_03_04_01,
    32'h02_05_00_00,
    32'h0B_04_02_02,
    32'h05_00_01_03,
    32'h3B_02_02_07,
    32'h06_00_00_05
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [7:0]  hostAddr = 8'd0;
  logic [31:0] hostWdata = 32'd0;
  logic [31:0] hostRdata;
  logic        spiSck, spiCsN, spiMosi;
  logic        spiMiso = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostSize(hostSize), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .spiSck(spiSck), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  function automatic logic [7:0] resp(input int k);
    return 8'((k * 37 + 92) & 255);
  endfunction

  function automatic logic [7:0] txPat(input int i, input logic [7:0] op);
    return 8'(i * 11 + int'(op) + 3);
  endfunction

  function automatic int expHalf(input logic [3:0] code);
    case (code)
      4'd4: return 1;
      4'd0: return 2;
      4'd1: return 3;
      4'd2: return 5;
      4'd3: return 6;
      default: return 125;
    endcase
  endfunction

  // Flash-side model, sampled away from the active edge
  logic [7:0] cap [140];
  int  cycle = 0, frameBit = 0;
  int  tCsFall = 0, tRise1 = 0, tFall1 = 0, tLastRise = 0, tCsRise = 0;
  bit  gotRise = 0, gotFall = 0;
  logic prevSck = 1'b0, prevCs = 1'b1;

  always @(negedge clk) begin
    cycle++;
    if (prevCs && !spiCsN) begin
      frameBit = 0; gotRise = 0; gotFall = 0; tCsFall = cycle;
      spiMiso = resp(0)[7];
    end
    if (!prevSck && spiSck) begin
      cap[frameBit / 8] = {cap[frameBit / 8][6:0], spiMosi};
      frameBit++;
      tLastRise = cycle;
      if (!gotRise) begin tRise1 = cycle; gotRise = 1; end
    end
    if (prevSck && !spiSck) begin
      if (!gotFall) begin tFall1 = cycle; gotFall = 1; end
      if (!spiCsN) spiMiso = resp(frameBit / 8)[7 - (frameBit % 8)];
    end
    if (!prevCs && spiCsN) tCsRise = cycle;
    prevSck = spiSck;
    prevCs  = spiCsN;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostSize = sz; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a; hostSize = sz;
    #1 d = hostRdata;
    hostSel = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int i = 0; i < 60000; i++) begin
      hostRead(8'h03, 2'd0, d);
      if (!d[7]) break;
    end
  endtask

  task automatic runXfer(input logic [7:0] op, input int tx, input int rx, input logic [3:0] code);
    logic [31:0] d;
    int h;
    h = expHalf(code);
    hostWrite(8'h22, 2'd1, {16'd0, code, code, code, code});
    hostWrite(8'h48, 2'd0, 32'(tx));
    hostWrite(8'h4B, 2'd0, 32'(rx));
    hostWrite(8'h00, 2'd0, {24'd0, op});
    for (int i = 0; i < tx; i += 4)
      hostWrite(8'(8'h80 + i), 2'd2, {txPat(i+3, op), txPat(i+2, op), txPat(i+1, op), txPat(i, op)});
    for (int i = 0; i < 140; i++) cap[i] = 8'h00;
    hostWrite(8'h02, 2'd0, 32'h1);
    hostRead(8'h00, 2'd2, d);
    chk(d[31] && d[16], "R3 busy/exec high during frame", d, 32'h80010000);
    chk(!d[20], "R6 error bit cleared by accepted start", d, 32'h0);
    waitIdle();
    hostRead(8'h00, 2'd2, d);
    chk(!d[31] && !d[16], "R3 busy/exec clear after frame", d, 32'h0);
    chk(cap[0] == op, "R4 opcode first", cap[0], op);
    for (int i = 0; i < tx; i++)
      chk(cap[1+i] == txPat(i, op), "R4 tx byte order", cap[1+i], txPat(i, op));
    for (int n = 0; n < rx; n++) begin
      chk(cap[1+tx+n] == 8'h00, "R4 MOSI low in receive phase", cap[1+tx+n], 0);
      hostRead(8'(8'h80 + ((tx + n) % DEPTH)), 2'd0, d);
      chk(d[7:0] == resp(1+tx+n), "R5 receive byte stored", d, resp(1+tx+n));
    end
    chk(tRise1 - tCsFall == 2*h, "R8 chip select lead", tRise1 - tCsFall, 2*h);
    chk(tFall1 - tRise1 == h, "R9 SCK high phase from speed code", tFall1 - tRise1, h);
    chk(tCsRise - tLastRise == h, "R8 chip select tail", tCsRise - tLastRise, h);
    chk(frameBit == 8*(1+tx+rx), "R4 frame length", frameBit, 8*(1+tx+rx));
  endtask

  initial begin
    #1200000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  keep;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    hostRead(8'h00, 2'd2, d); chk(d == 32'h0, "R1 control word reset", d, 0);
    hostRead(8'h20, 2'd0, d); chk(d == 32'h0, "R1 enable reset", d, 0);
    hostRead(8'h22, 2'd1, d); chk(d == 32'h0, "R1 speed reset", d, 0);
    hostRead(8'h80, 2'd2, d); chk(d == 32'h0, "R1 buffer reset", d, 0);
    chk(spiCsN && !spiSck, "R1 SPI lines idle", {spiCsN, spiSck}, 2'b10);

    // R2 readback across lane widths
    hostWrite(8'h22, 2'd1, 32'h4127);
    hostRead(8'h22, 2'd1, d); chk(d == 32'h4127, "R2 speed halfword", d, 32'h4127);
    hostRead(8'h23, 2'd0, d); chk(d == 32'h41, "R2 speed upper byte", d, 32'h41);
    hostWrite(8'h00, 2'd2, 32'h400400AB);
    hostRead(8'h00, 2'd2, d); chk(d == 32'h400400AB, "R2 opcode and read mode", d, 32'h400400AB);
    hostWrite(8'h48, 2'd0, 32'h12);
    hostWrite(8'h4B, 2'd0, 32'h34);
    hostRead(8'h4A, 2'd1, d); chk(d == 32'h3400, "R2 rx count halfword lane", d, 32'h3400);
    hostRead(8'h48, 2'd0, d); chk(d == 32'h12, "R2 tx count byte", d, 32'h12);

    // R7 execute ignored while disabled
    hostWrite(8'h48, 2'd0, 32'h0);
    hostWrite(8'h4B, 2'd0, 32'h0);
    hostWrite(8'h02, 2'd0, 32'h1);
    repeat (5) @(negedge clk);
    hostRead(8'h00, 2'd2, d);
    chk(!d[31] && spiCsN, "R7 no frame while disabled", d, 32'h400400AB);

    hostWrite(8'h20, 2'd0, 32'h1);
    hostRead(8'h20, 2'd0, d); chk(d == 32'h1, "R2 enable readback", d, 1);

    // Vector table: R3 R4 R5 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      e = VEC[v];
      runXfer(e[31:24], int'(e[23:16]), int'(e[15:8]), e[3:0]);
    end

    // R6 over-limit counts rejected
    hostWrite(8'h48, 2'd0, 32'd69);
    hostWrite(8'h4B, 2'd0, 32'd0);
    hostWrite(8'h02, 2'd0, 32'h1);
    repeat (4) @(negedge clk);
    hostRead(8'h00, 2'd2, d);
    chk(d[20] && !d[31] && spiCsN, "R6 tx over limit rejected", d, 32'h00100000);
    hostWrite(8'h48, 2'd0, 32'd0);
    hostWrite(8'h4B, 2'd0, 32'd69);
    hostWrite(8'h02, 2'd0, 32'h1);
    repeat (4) @(negedge clk);
    hostRead(8'h00, 2'd2, d);
    chk(d[20] && !d[31] && spiCsN, "R6 rx over limit rejected", d, 32'h00100000);

    // R5 wrap at the buffer end, limit-size payload accepted
    runXfer(8'hA7, 68, 5, 4'd4);
    hostRead(8'h82, 2'd0, d);
    chk(d[7:0] == txPat(2, 8'hA7), "R5 entry outside receive window kept", d, txPat(2, 8'hA7));

    // R10 writes ignored during a frame
    hostRead(8'h8A, 2'd0, d); keep = d[7:0];
    hostWrite(8'h22, 2'd1, 32'h3333);
    hostWrite(8'h48, 2'd0, 32'd0);
    hostWrite(8'h4B, 2'd0, 32'd2);
    hostWrite(8'h00, 2'd0, 32'h35);
    hostWrite(8'h02, 2'd0, 32'h1);
    hostWrite(8'h00, 2'd0, 32'hEE);
    hostWrite(8'h48, 2'd0, 32'd9);
    hostWrite(8'h8A, 2'd0, 32'h77);
    hostWrite(8'h22, 2'd1, 32'h0);
    waitIdle();
    hostRead(8'h00, 2'd0, d); chk(d == 32'h35, "R10 opcode unchanged", d, 32'h35);
    hostRead(8'h48, 2'd0, d); chk(d == 32'h0, "R10 tx count unchanged", d, 0);
    hostRead(8'h8A, 2'd0, d); chk(d[7:0] == keep, "R10 buffer unchanged", d, keep);
    hostRead(8'h22, 2'd1, d); chk(d == 32'h3333, "R10 speed unchanged", d, 32'h3333);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule